// File: doc/BRIEF.md
# Virtual Supervisor Top-Interrupt Arbiter

This block produces the top-interrupt word seen by a virtual supervisor. Each cycle it gathers at most two candidates. The first is an external candidate, whose identity is always 9. It comes either from the guest external interrupt selection or from the hypervisor's virtual-interrupt control fields. The second comes either from an injected interrupt described by the control fields or from the best pending and enabled virtual-supervisor interrupt. The block keeps the candidate with the numerically lowest priority and then adjusts that priority according to a priority-mode flag. The adjustment can clamp the value, substitute a value for zero, or force the value to 1.

The result is registered. The word on the output describes the inputs present at the previous rising clock edge. The interrupt file that supplies the top guest external priority is outside this block.

Top module: `vs_topi_arb`

## Requirements
- R1: When `gsel_idx` is nonzero, an external candidate with identity 9 exists if three conditions hold: `gext_pend[gsel_idx]` or `vs_pend[9]` is set, `vs_en[9]` is set, and `gsel_idx <= gext_count`.
- R2: The external candidate of R1 has priority 256. When `file_top_prio` is nonzero, that value is used instead.
- R3: When `gsel_idx` is zero, an external candidate with identity 9 and priority `ctl_prio` exists only if `ctl_iid` is 9 and `ctl_prio` is nonzero.
- R4: When `ctl_inject` is 1 and `ctl_iid` is not 9, a second candidate with identity `ctl_iid` and priority `ctl_prio` exists.
- R5: When `ctl_inject` is 0, the second candidate is the pending and enabled interrupt among identities 1 to NIRQ-1 with the lowest `iprio` entry. On equal entries the lower identity is taken. The candidate exists only if such an interrupt is found and its identity is not 9. Entry i of `iprio` occupies bits 8i+7:8i.
- R6: The winner is the candidate with the strictly lower priority. When the two priorities are equal, the external candidate wins.
- R7: When `ctl_prio_mode` is 1, a winner priority above 255 is reported as 255.
- R8: When `ctl_prio_mode` is 1, a winner priority of 0 is reported as 255 if the identity is greater than 9 and stays 0 otherwise.
- R9: When `ctl_prio_mode` is 0, any winner with a nonzero identity is reported with priority 1.
- R10: With no candidate, or with a winning identity of 0, the whole word is zero.
- R11: `topi_word` carries the identity in bits 27:16 and the priority in bits 7:0, with all other bits zero. It reflects the inputs one clock edge earlier and is zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| gsel_idx | input | GSW | Guest external select index |
| gext_count | input | GSW | Number of implemented guest external interrupts |
| gext_pend | input | 2**GSW | Guest external pending vector |
| vs_pend | input | NIRQ | Virtual-supervisor pending vector |
| vs_en | input | NIRQ | Virtual-supervisor enable vector |
| iprio | input | 8*NIRQ | Per-interrupt priorities, 8 bits each |
| ctl_iid | input | 12 | Control field: injected identity |
| ctl_prio | input | 8 | Control field: injected priority |
| ctl_inject | input | 1 | Control field: inject flag |
| ctl_prio_mode | input | 1 | Control field: priority-mode flag |
| file_top_prio | input | 8 | Top priority reported by the interrupt file |
| topi_word | output | 32 | Registered identity/priority word |

## Verification
On every cycle the assertions check the following properties of the word:
- The unused bits are zero, and an empty identity carries a zero priority.
- The priority is forced to 1 when the priority mode was clear.
- No identity above 9 is reported with a zero priority under priority mode.
- Two specific input combinations produce the expected word: the clamp of the default external priority 256, and the index-zero external path.

Candidate gathering, the lowest-priority search over the pending vector with its tie order, and the tie between the two candidates depend on full input combinations. Only the bench's sweeps and directed scenarios show these.

// File: rtl/vs_arb_pkg.sv
package vs_arb_pkg;
    localparam int PRIO_W = 8;
    localparam int CMP_W  = PRIO_W + 1;
    localparam int IID_W  = 12;
    localparam logic [IID_W-1:0] EXT_IID = IID_W'(9);
    localparam logic [CMP_W-1:0] EXT_DEFAULT_PRIO = CMP_W'(256);
    localparam logic [PRIO_W-1:0] PRIO_MAX = '1;

    typedef struct packed {
        logic              vld;
        logic [IID_W-1:0]  iid;
        logic [CMP_W-1:0]  prio;
    } cand_t;

    typedef struct packed {
        logic [IID_W-1:0]  iid;
        logic [PRIO_W-1:0] prio;
    } topi_t;
endpackage

// File: rtl/vs_pend_pick.sv
module vs_pend_pick
    import vs_arb_pkg::*;
#(
    parameter int NIRQ  = 16,
    localparam int IDX_W = $clog2(NIRQ)
) (
    input  logic [NIRQ-1:0]        pend,
    input  logic [NIRQ-1:0]        en,
    input  logic [NIRQ*PRIO_W-1:0] iprio,
    output logic                   found,
    output logic [IDX_W-1:0]       idx,
    output logic [PRIO_W-1:0]      prio
);
    logic [NIRQ-1:0] live;
    assign live = pend & en;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        prio  = '0;
        // identity 0 never takes part; scan upward so ties keep the lower id
        for (int i = 1; i < NIRQ; i++) begin
            if (live[i] && (!found || (iprio[i*PRIO_W +: PRIO_W] < prio))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                prio  = iprio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/vs_cand_gather.sv
module vs_cand_gather
    import vs_arb_pkg::*;
#(
    parameter int GSW   = 6,
    parameter int IDX_W = 4
) (
    input  logic [GSW-1:0]      gsel_idx,
    input  logic [GSW-1:0]      gext_count,
    input  logic [2**GSW-1:0]   gext_pend,
    input  logic                ext_pend,
    input  logic                ext_en,
    input  logic [IID_W-1:0]    ctl_iid,
    input  logic [PRIO_W-1:0]   ctl_prio,
    input  logic                ctl_inject,
    input  logic [PRIO_W-1:0]   file_top_prio,
    input  logic                pick_found,
    input  logic [IDX_W-1:0]    pick_idx,
    input  logic [PRIO_W-1:0]   pick_prio,
    output cand_t               ext_c,
    output cand_t               oth_c
);
    logic sel_live;
    assign sel_live = (gext_pend[gsel_idx] | ext_pend) & ext_en & (gsel_idx <= gext_count);

    always_comb begin
        ext_c = '0;
        if (gsel_idx != '0) begin
            if (sel_live) begin
                ext_c.vld  = 1'b1;
                ext_c.iid  = EXT_IID;
                ext_c.prio = (file_top_prio != '0) ? CMP_W'(file_top_prio) : EXT_DEFAULT_PRIO;
            end
        end else if (ctl_iid == EXT_IID && ctl_prio != '0) begin
            ext_c.vld  = 1'b1;
            ext_c.iid  = EXT_IID;
            ext_c.prio = CMP_W'(ctl_prio);
        end
    end

    always_comb begin
        oth_c = '0;
        if (ctl_inject) begin
            if (ctl_iid != EXT_IID) begin
                oth_c.vld  = 1'b1;
                oth_c.iid  = ctl_iid;
                oth_c.prio = CMP_W'(ctl_prio);
            end
        end else if (pick_found && IID_W'(pick_idx) != EXT_IID) begin
            oth_c.vld  = 1'b1;
            oth_c.iid  = IID_W'(pick_idx);
            oth_c.prio = CMP_W'(pick_prio);
        end
    end
endmodule

// File: rtl/vs_topi_arb.sv
module vs_topi_arb
    import vs_arb_pkg::*;
#(
    parameter int NIRQ = 16,
    parameter int GSW  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [GSW-1:0]         gsel_idx,
    input  logic [GSW-1:0]         gext_count,
    input  logic [2**GSW-1:0]      gext_pend,
    input  logic [NIRQ-1:0]        vs_pend,
    input  logic [NIRQ-1:0]        vs_en,
    input  logic [NIRQ*8-1:0]      iprio,
    input  logic [11:0]            ctl_iid,
    input  logic [7:0]             ctl_prio,
    input  logic                   ctl_inject,
    input  logic                   ctl_prio_mode,
    input  logic [7:0]             file_top_prio,
    output logic [31:0]            topi_word
);
    localparam int IDX_W = $clog2(NIRQ);

    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic [PRIO_W-1:0] pick_prio;
    cand_t             ext_c, oth_c, win_c;
    topi_t             res_d, res_q;

    vs_pend_pick #(.NIRQ(NIRQ)) u_pick (
        .pend  (vs_pend),
        .en    (vs_en),
        .iprio (iprio),
        .found (pick_found),
        .idx   (pick_idx),
        .prio  (pick_prio)
    );

    vs_cand_gather #(.GSW(GSW), .IDX_W(IDX_W)) u_gather (
        .gsel_idx      (gsel_idx),
        .gext_count    (gext_count),
        .gext_pend     (gext_pend),
        .ext_pend      (vs_pend[9]),
        .ext_en        (vs_en[9]),
        .ctl_iid       (ctl_iid),
        .ctl_prio      (ctl_prio),
        .ctl_inject    (ctl_inject),
        .file_top_prio (file_top_prio),
        .pick_found    (pick_found),
        .pick_idx      (pick_idx),
        .pick_prio     (pick_prio),
        .ext_c         (ext_c),
        .oth_c         (oth_c)
    );

    always_comb begin
        // strict compare: equal priorities leave the external candidate in place
        win_c = ext_c;
        if (oth_c.vld && (!ext_c.vld || oth_c.prio < ext_c.prio)) begin
            win_c = oth_c;
        end

        res_d = '0;
        if (win_c.vld && win_c.iid != '0) begin
            res_d.iid = win_c.iid;
            if (ctl_prio_mode) begin
                if (win_c.prio > CMP_W'(PRIO_MAX)) begin
                    res_d.prio = PRIO_MAX;
                end else if (win_c.prio == '0 && win_c.iid > EXT_IID) begin
                    res_d.prio = PRIO_MAX;
                end else begin
                    res_d.prio = win_c.prio[PRIO_W-1:0];
                end
            end else begin
                res_d.prio = PRIO_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign topi_word = {4'd0, res_q.iid, 8'd0, res_q.prio};
endmodule

// File: rtl/vs_topi_chk.sv
module vs_topi_chk #(
    parameter int NIRQ = 16,
    parameter int GSW  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [GSW-1:0]         gsel_idx,
    input  logic [GSW-1:0]         gext_count,
    input  logic [2**GSW-1:0]      gext_pend,
    input  logic [NIRQ-1:0]        vs_pend,
    input  logic [NIRQ-1:0]        vs_en,
    input  logic [NIRQ*8-1:0]      iprio,
    input  logic [11:0]            ctl_iid,
    input  logic [7:0]             ctl_prio,
    input  logic                   ctl_inject,
    input  logic                   ctl_prio_mode,
    input  logic [7:0]             file_top_prio,
    input  logic [31:0]            topi_word
);
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R11
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (topi_word[31:28] == 4'd0) && (topi_word[15:8] == 8'd0));

    // R10
    empty_id_zero_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (topi_word[27:16] == 12'd0) |-> (topi_word[7:0] == 8'd0));

    // R9
    mode_clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!ctl_prio_mode) && topi_word[27:16] != 12'd0) |-> (topi_word[7:0] == 8'd1));

    // R8
    high_id_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(ctl_prio_mode) && topi_word[27:16] > 12'd9) |-> (topi_word[7:0] != 8'd0));

    // R7
    ext_default_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(ctl_prio_mode && gsel_idx != '0 && gsel_idx <= gext_count && vs_en[9] && vs_pend[9]
                        && file_top_prio == 8'd0 && ctl_inject && ctl_iid == 12'd9))
        |-> (topi_word == {4'd0, 12'd9, 8'd0, 8'd255}));

    // R3
    sel_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(gsel_idx == '0 && ctl_iid == 12'd9 && ctl_prio != 8'd0 && ctl_inject))
        |-> (topi_word[27:16] == 12'd9));
endmodule

bind vs_topi_arb vs_topi_chk #(.NIRQ(NIRQ), .GSW(GSW)) u_chk (.*);

// File: tb/tb_vs_topi_arb.sv
module tb_vs_topi_arb;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 16;
    localparam int GSW  = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [GSW-1:0]       gsel_idx = '0;
    logic [GSW-1:0]       gext_count = '0;
    logic [2**GSW-1:0]    gext_pend = '0;
    logic [NIRQ-1:0]      vs_pend = '0;
    logic [NIRQ-1:0]      vs_en = '0;
    logic [NIRQ*8-1:0]    iprio;
    logic [11:0]          ctl_iid = '0;
    logic [7:0]           ctl_prio = '0;
    logic                 ctl_inject = 1'b0;
    logic                 ctl_prio_mode = 1'b0;
    logic [7:0]           file_top_prio = '0;
    logic [31:0]          topi_word;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vs_topi_arb #(.NIRQ(NIRQ), .GSW(GSW)) dut (.*);

    function automatic int prio_of(int i);
        return (i * 3) % 11;
    endfunction

    initial begin
        for (int i = 0; i < NIRQ; i++) iprio[i*8 +: 8] = 8'(prio_of(i));
    end

    function automatic logic [31:0] model();
        bit ev = 0, ov = 0;
        int ep = 0, op = 0, oid = 0, wid = 0, wp = 0, bi = -1, bp = 0, rp;
        bit wv;
        if (gsel_idx != 0) begin
            if ((gext_pend[gsel_idx] || vs_pend[9]) && vs_en[9] && gsel_idx <= gext_count) begin
                ev = 1; ep = (file_top_prio != 0) ? int'(file_top_prio) : 256;
            end
        end else if (ctl_iid == 9 && ctl_prio != 0) begin
            ev = 1; ep = ctl_prio;
        end
        if (ctl_inject) begin
            if (ctl_iid != 9) begin ov = 1; oid = ctl_iid; op = ctl_prio; end
        end else begin
            for (int i = 1; i < NIRQ; i++)
                if (vs_pend[i] && vs_en[i] && (bi < 0 || prio_of(i) < bp)) begin bi = i; bp = prio_of(i); end
            if (bi > 0 && bi != 9) begin ov = 1; oid = bi; op = bp; end
        end
        wv = ev; wid = 9; wp = ep;
        if (ov && (!ev || op < ep)) begin wv = 1; wid = oid; wp = op; end
        if (!wv || wid == 0) return 32'd0;
        if (ctl_prio_mode) begin
            rp = wp;
            if (rp > 255) rp = 255;
            else if (rp == 0 && wid > 9) rp = 255;
        end else rp = 1;
        return {4'd0, 12'(wid), 8'd0, 8'(rp)};
    endfunction

    task automatic check(string tag, logic [31:0] exp);
        total++;
        if (topi_word !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, topi_word, exp);
        end
    endtask

    task automatic step_check(string tag, logic [31:0] exp);
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic clear_inputs();
        gsel_idx = 0; gext_count = 0; gext_pend = 0; vs_pend = 0; vs_en = 0;
        ctl_iid = 0; ctl_prio = 0; ctl_inject = 0; ctl_prio_mode = 1; file_top_prio = 0;
    endtask

    task automatic set_pat(int p);
        case (p)
            0: begin vs_pend = 0; vs_en = 0; end
            1: begin vs_pend = 16'h1208; vs_en = 16'h1208; end
            2: begin vs_pend = 16'h4600; vs_en = 16'h4400; end
            3: begin vs_pend = 16'h0A08; vs_en = 16'h0A08; end
            default: begin vs_pend = 16'h2200; vs_en = 16'h2200; end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ids[4]  = '{0, 5, 9, 12};
        int prs[3]  = '{0, 3, 255};
        clear_inputs();
        repeat (3) @(negedge clk);
        check("R11 reset", 32'd0);
        rst_n = 1'b1;

        // R1 selected guest external bit with virtual external enable
        clear_inputs(); gsel_idx = 2; gext_count = 2; gext_pend = 64'h4; vs_en = 16'h0200;
        step_check("R1 ext via select", {4'd0, 12'd9, 8'd0, 8'd255});
        // R2 file priority replaces default
        file_top_prio = 4;
        step_check("R2 file prio", {4'd0, 12'd9, 8'd0, 8'd4});
        // R1 index beyond count gives no candidate
        gsel_idx = 3; gext_pend = 64'h8;
        step_check("R1 index over count", 32'd0);
        // R1 enable missing
        gsel_idx = 2; gext_pend = 64'h4; vs_en = 0;
        step_check("R1 enable clear", 32'd0);
        // R3 index zero path
        clear_inputs(); ctl_iid = 9; ctl_prio = 7;
        step_check("R3 index zero ext", {4'd0, 12'd9, 8'd0, 8'd7});
        ctl_prio = 0;
        step_check("R3 zero prio none", 32'd0);
        // R4 injected candidate
        clear_inputs(); ctl_inject = 1; ctl_iid = 5; ctl_prio = 3;
        step_check("R4 inject", {4'd0, 12'd5, 8'd0, 8'd3});
        // R5 pending pick, 10 prio 8 beats 14 prio 9, 9 not enabled
        clear_inputs(); set_pat(2);
        step_check("R5 pending pick", {4'd0, 12'd10, 8'd0, 8'd8});
        // R5 pick lands on 9, so no second candidate
        clear_inputs(); set_pat(4);
        step_check("R5 pick is nine", 32'd0);
        // R6 tie, external wins
        clear_inputs(); set_pat(2); vs_en = 16'h0400; ctl_iid = 9; ctl_prio = 8;
        step_check("R6 tie ext wins", {4'd0, 12'd9, 8'd0, 8'd8});
        // R7 default 256 clamped
        clear_inputs(); gsel_idx = 1; gext_count = 1; vs_pend = 16'h0200; vs_en = 16'h0200;
        step_check("R7 clamp", {4'd0, 12'd9, 8'd0, 8'd255});
        // R8 zero prio above 9 -> 255
        clear_inputs(); set_pat(3);
        step_check("R8 zero sub", {4'd0, 12'd11, 8'd0, 8'd255});
        // R8 zero prio below 9 stays zero
        clear_inputs(); ctl_inject = 1; ctl_iid = 5; ctl_prio = 0;
        step_check("R8 zero kept", {4'd0, 12'd5, 8'd0, 8'd0});
        // R9 mode clear
        clear_inputs(); set_pat(3); ctl_prio_mode = 0;
        step_check("R9 forced one", {4'd0, 12'd11, 8'd0, 8'd1});
        // R10 injected identity zero
        clear_inputs(); ctl_inject = 1; ctl_iid = 0; ctl_prio = 3;
        step_check("R10 id zero", 32'd0);

        // sweep across candidate sources and modes (R1 through R11 combined)
        for (int g = 0; g < 4; g++)
        for (int c = 0; c < 2; c++)
        for (int gp = 0; gp < 2; gp++)
        for (int p = 0; p < 5; p++)
        for (int inj = 0; inj < 2; inj++)
        for (int md = 0; md < 2; md++)
        for (int k = 0; k < 4; k++)
        for (int q = 0; q < 3; q++)
        for (int f = 0; f < 2; f++) begin
            logic [31:0] exp;
            gsel_idx = GSW'(g); gext_count = GSW'(c * 2);
            gext_pend = gp ? 64'h4 : 64'h0; set_pat(p);
            ctl_inject = inj[0]; ctl_prio_mode = md[0];
            ctl_iid = 12'(ids[k]); ctl_prio = 8'(prs[q]); file_top_prio = f ? 8'd4 : 8'd0;
            exp = model();
            step_check("R6 sweep", exp);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule